// File: doc/BRIEF.md
# Charge Pump Enable Sequencer

This block decides when a charge-pump power converter runs. An active-high enable pin starts it and stops it. After each accepted start the block holds a clock-selector override for a fixed startup window, so the pump runs on the internal clock until the pin-selected clock is allowed to take over. The positive regulator turns on with the pump. The negative regulator waits until a comparator reports that the positive rail has crossed its threshold.

Overcurrent flags from either rail are ignored during a masking window that starts at the start. After that window, a flag latches the converter off with every output dark. Only a low-then-high cycle on the enable pin clears the latch. When enable falls, the regulators stop at once. The pump keeps running for a fixed stop interval and then stops. A start is accepted only after enable has been seen low while the supply-good flag was true. Losing supply-good returns the block to idle in any state. All windows are counted in ticks of the clock input.

Top module: `cp_enable_seq`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it, all five outputs are 0.
- R2: An accepted start drives pump_en_o and boot_clk_o high in the next cycle. boot_clk_o stays high for exactly START_TICKS cycles and then falls while pump_en_o stays high.
- R3: Overcurrent flags are ignored during the first MASK_TICKS cycles counted from the first cycle of a start. A flag present only in that window leaves fault_o at 0 and the pump running.
- R4: A flag (fault_vh_i or fault_vl_i) seen in cycle MASK_TICKS or later of a start or run makes fault_o 1 and the other four outputs 0 in the next cycle.
- R5: fault_o stays 1 while en_i stays high. After en_i is driven low it drops to 0 in the next cycle. A following rise of en_i starts the converter again.
- R6: When en_i falls during startup or run, the regulator enables and boot_clk_o drop in the next cycle. pump_en_o stays high for exactly STOP_TICKS cycles and then falls.
- R7: A rise of en_i during the stop interval does not shorten or extend it. After one idle cycle with pump_en_o at 0, the start is taken.
- R8: No start occurs unless en_i was seen low while supply_ok_i was 1 since the last start, reset or supply loss. Enable held high through reset or through a supply return starts nothing.
- R9: vh_reg_en_o is high during startup and run. vl_reg_en_o rises only in the cycle after vh_above_i was sampled high during startup or run.
- R10: supply_ok_i at 0 turns every output off in the next cycle, whatever the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | tick clock from the internal oscillator |
| rst_ni | input | 1 | active-low asynchronous reset |
| en_i | input | 1 | enable pin, active high |
| supply_ok_i | input | 1 | supply above its operating minimum |
| fault_vh_i | input | 1 | positive rail overcurrent flag |
| fault_vl_i | input | 1 | negative rail overcurrent flag |
| vh_above_i | input | 1 | positive rail above its threshold |
| pump_en_o | output | 1 | charge pump running |
| boot_clk_o | output | 1 | force the internal startup clock in the selector |
| vh_reg_en_o | output | 1 | positive regulator enable |
| vl_reg_en_o | output | 1 | negative regulator enable |
| fault_o | output | 1 | latched short-circuit shutdown |

## Verification
The bench applies overcurrent pulses at two points. One pulse falls well inside the masking window. The other starts one cycle before the window ends and is held into its first open cycle, which shows whether the mask is off by one. It drops enable during run and re-raises it in the middle of the stop interval, so a sequencer that restarts early shows a different pump profile from one that finishes the stop first. It holds enable high through reset and through a supply loss and return, which tells a level-triggered start apart from one that needs the enable low first. It also delays the rail comparator, which shows whether the negative regulator waits for it.

// File: rtl/cp_seq_pkg.sv
package cp_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STARTUP,
    ST_RUN,
    ST_STOPPING,
    ST_FAULT
  } seq_state_e;
endpackage

// File: rtl/cp_seq_timer.sv
// Saturating window counter; runs while run_i, clears otherwise.
module cp_seq_timer #(
  parameter int unsigned LIMIT     = 16,
  parameter bit          LAST_TICK = 1'b1  // 1: flag last cycle of window, 0: flag window elapsed
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (LAST_TICK) begin : g_last
      assign hit_o = run_i && (cnt_q == CW'(LIMIT - 1));
    end else begin : g_full
      assign hit_o = run_i && (cnt_q == CNT_MAX);
    end
  endgenerate

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  p_cnt_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/cp_seq_arm.sv
// Start qualifier: set by enable low with supply good, cleared by a taken start or supply loss.
module cp_seq_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic supply_ok_i,
  input  logic take_i,
  output logic armed_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          armed_q <= 1'b0;
    else if (!supply_ok_i) armed_q <= 1'b0;
    else if (take_i)      armed_q <= 1'b0;
    else if (!en_i)       armed_q <= 1'b1;
  end

  assign armed_o = armed_q;

  p_arm_needs_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(!en_i && supply_ok_i));
endmodule

// File: rtl/cp_enable_seq.sv
module cp_enable_seq
  import cp_seq_pkg::*;
#(
  parameter int unsigned START_TICKS = 18800,  // 9.4 ms at 2 MHz
  parameter int unsigned MASK_TICKS  = 36000,  // 18 ms at 2 MHz
  parameter int unsigned STOP_TICKS  = 15000   // 7.5 ms at 2 MHz
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic supply_ok_i,
  input  logic fault_vh_i,
  input  logic fault_vl_i,
  input  logic vh_above_i,
  output logic pump_en_o,
  output logic boot_clk_o,
  output logic vh_reg_en_o,
  output logic vl_reg_en_o,
  output logic fault_o
);
  seq_state_e state_q, state_d;
  logic armed, take, running, in_start, in_stop;
  logic start_last, stop_last, mask_over, fault_hit;
  logic vh_ok_q;

  assign in_start = (state_q == ST_STARTUP);
  assign in_stop  = (state_q == ST_STOPPING);
  assign running  = in_start || (state_q == ST_RUN);

  cp_seq_arm u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .supply_ok_i(supply_ok_i),
    .take_i     (take),
    .armed_o    (armed)
  );

  cp_seq_timer #(.LIMIT(START_TICKS), .LAST_TICK(1'b1)) u_start_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(in_start), .hit_o(start_last)
  );

  // Mask spans startup and run without a restart at the boundary.
  cp_seq_timer #(.LIMIT(MASK_TICKS), .LAST_TICK(1'b0)) u_mask_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(running), .hit_o(mask_over)
  );

  cp_seq_timer #(.LIMIT(STOP_TICKS), .LAST_TICK(1'b1)) u_stop_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(in_stop), .hit_o(stop_last)
  );

  assign take      = (state_q == ST_IDLE) && supply_ok_i && en_i && armed;
  assign fault_hit = mask_over && (fault_vh_i || fault_vl_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (take) state_d = ST_STARTUP;
      ST_STARTUP: begin
        if (fault_hit)       state_d = ST_FAULT;
        else if (!en_i)      state_d = ST_STOPPING;
        else if (start_last) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (fault_hit)       state_d = ST_FAULT;
        else if (!en_i)      state_d = ST_STOPPING;
      end
      ST_STOPPING: if (stop_last) state_d = ST_IDLE;
      ST_FAULT:    if (!en_i)     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
    if (!supply_ok_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // Sticky rail-good flag for the negative regulator.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 vh_ok_q <= 1'b0;
    else if (!running)           vh_ok_q <= 1'b0;
    else if (vh_above_i)         vh_ok_q <= 1'b1;
  end

  assign pump_en_o   = running || in_stop;
  assign boot_clk_o  = in_start;
  assign vh_reg_en_o = running;
  assign vl_reg_en_o = running && vh_ok_q;
  assign fault_o     = (state_q == ST_FAULT);

  p_fault_after_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(mask_over));
  p_fault_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && en_i && supply_ok_i |=> fault_o);
  p_stop_keeps_pump_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vh_reg_en_o) && $past(supply_ok_i) && !fault_o |-> pump_en_o);
  p_start_armed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(boot_clk_o) |-> $past(armed));
  p_vl_after_vh_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vl_reg_en_o) |-> $past(vh_above_i));
  p_supply_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !pump_en_o && !fault_o);
  p_single_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({boot_clk_o, fault_o, in_stop}));
endmodule

// File: tb/tb_cp_enable_seq.sv
module tb_cp_enable_seq;
  localparam int CLK_PERIOD = 10;
  localparam int START = 20;
  localparam int MASK  = 40;
  localparam int STOP  = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sup = 1'b0, fvh = 1'b0, fvl = 1'b0, vh_above = 1'b0;
  logic pump, boot, vhr, vlr, flt;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp_enable_seq #(.START_TICKS(START), .MASK_TICKS(MASK), .STOP_TICKS(STOP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .supply_ok_i(sup),
    .fault_vh_i(fvh), .fault_vl_i(fvl), .vh_above_i(vh_above),
    .pump_en_o(pump), .boot_clk_o(boot), .vh_reg_en_o(vhr),
    .vl_reg_en_o(vlr), .fault_o(flt)
  );

  // Outputs as {pump, boot, vh_reg, vl_reg, fault}
  function automatic logic [4:0] outs();
    return {pump, boot, vhr, vlr, flt};
  endfunction

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [4:0] exp);
    total++;
    if (outs() !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, outs(), exp, $time);
    end
  endtask

  task automatic do_reset(input logic en_v);
    rst_n = 1'b0; en = en_v; sup = 1'b1; fvh = 0; fvl = 0; vh_above = 0;
    tick(2);
    check("R1 in reset", 5'b00000);
    rst_n = 1'b1;
    tick(1);
    check("R1 after reset", 5'b00000);
  endtask

  // Leaves the design in the first startup cycle.
  task automatic start();
    en = 1'b0; tick(1);
    en = 1'b1; tick(1);
  endtask

  task automatic t_startup_window();
    do_reset(1'b0);
    start();
    check("R2 start cycle", 5'b11100);
    tick(START - 1);
    check("R2 last boot cycle", 5'b11100);
    tick(1);
    check("R2 boot released", 5'b10100);
  endtask

  task automatic t_vl_gate();
    do_reset(1'b0);
    start();
    tick(3);
    check("R9 vl waits", 5'b11100);
    vh_above = 1'b1; tick(1);
    check("R9 vl on", 5'b11110);
    sup = 1'b0; tick(1);
    check("R10 supply drop", 5'b00000);
    sup = 1'b1; tick(3);
    check("R8 no start on supply return", 5'b00000);
    vh_above = 1'b0;
  endtask

  task automatic t_mask_and_fault();
    do_reset(1'b0);
    start();
    tick(4);
    fvh = 1'b1; tick(1); fvh = 1'b0;
    check("R3 early pulse ignored", 5'b11100);
    tick(MASK - 1 - 5);
    check("R3 last masked cycle", 5'b10100);
    fvl = 1'b1; tick(1);
    check("R3 mask edge", 5'b10100);
    tick(1);
    check("R4 latched off", 5'b00001);
    fvl = 1'b0;
    tick(5);
    check("R5 latch holds", 5'b00001);
    en = 1'b0; tick(1);
    check("R5 cleared", 5'b00000);
    en = 1'b1; tick(1);
    check("R5 restart", 5'b11100);
  endtask

  task automatic t_stop();
    do_reset(1'b0);
    vh_above = 1'b1;
    start();
    tick(START);
    check("R6 run", 5'b10110);
    en = 1'b0; tick(1);
    check("R6 stop begins", 5'b10000);
    tick(STOP - 1);
    check("R6 last stop cycle", 5'b10000);
    tick(1);
    check("R6 stopped", 5'b00000);
    vh_above = 1'b0;
  endtask

  task automatic t_stop_reenable();
    do_reset(1'b0);
    start();
    tick(2);
    en = 1'b0; tick(1);
    tick(2);
    en = 1'b1;
    tick(STOP - 3);
    check("R7 stop runs out", 5'b10000);
    tick(1);
    check("R7 idle cycle", 5'b00000);
    tick(1);
    check("R7 start after idle", 5'b11100);
  endtask

  task automatic t_no_arm();
    do_reset(1'b1);
    tick(5);
    check("R8 enable held through reset", 5'b00000);
    en = 1'b0; tick(1);
    en = 1'b1; tick(1);
    check("R8 start after low", 5'b11100);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_startup_window();
    t_vl_gate();
    t_mask_and_fault();
    t_stop();
    t_stop_reenable();
    t_no_arm();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule